// File: doc/BRIEF.md
# Command Packet Dispatcher

This block sits behind a byte-level transfer engine. Each time the engine has collected a whole packet from the host, it hands over the bytes and the length with a single-cycle strobe. The dispatcher looks at the leading byte. A value of 0 marks a request for the peripheral bus, and the dispatcher forwards it through a request/response stub port. A value of 1 marks a controller command, which the dispatcher decodes locally. Every accepted packet gets exactly one framed reply, presented to the engine as a byte array plus a length.

A controller command is decoded in one step. The block checks that the argument count is exactly the one that command requires. If it is, the block performs the command's small action and returns a success frame that echoes the command byte. The actions are: update the autopoll enable, the poll rate or the 16-bit device mask; fire a power-off or system-reset pulse; read or set a 32-bit seconds clock. A wrong argument count or an unknown command code produces a four-byte error frame instead. The seconds clock is kept as an offset added to a counter, and that counter advances on an external once-per-second strobe.

Top module: `cmd_pkt_dispatch`

## Requirements
- R1: A packet is accepted only in the idle state. Byte 0 is the type: 0 means bus request and needs length of at least 1; 1 means command and needs length of at least 2. Any other type, or a shorter packet, produces no reply and no bus request.
- R2: An accepted command produces a reply pulse at the first clock edge after the packet strobe. A success reply holds byte 0 = 0x01, byte 1 = 0x00, byte 2 = the command byte, then the result bytes. Its length is 3 plus the number of results, and every unused reply byte is zero.
- R3: A known command whose argument count (length minus 2) is not its required count gets the reply 0x02, 0x05, 0x01, cmd with length 4, and causes no side effect.
- R4: A command byte outside the table gets the reply 0x02, 0x02, 0x01, cmd with length 4.
- R5: Required argument counts are: 0x01 autopoll 1, 0x03 clock read 0, 0x09 clock set 4, 0x0A power-off 0, 0x11 system reset 0, 0x13 file-server flag 1, 0x14 poll rate 1, 0x19 device mask 2, 0x21 power messages 1. Commands 0x13 and 0x21 have no side effect.
- R6: Poll rate (0x14) stores its argument. An argument of zero is rejected with the 0x05 error and leaves the rate unchanged. The rate resets to RATE_INIT.
- R7: Autopoll (0x01) sets autopoll_en to 1 when its argument is nonzero and to 0 otherwise. It resets to 0.
- R8: Device mask (0x19) stores {arg0, arg1}, so arg0 is the high byte. It resets to 0 and changes only together with its success reply.
- R9: The seconds count increments on each sec_tick. Clock set (0x09) stores offset = value minus count, with the value taken from args 0..3, most significant byte first. Clock read (0x03) returns offset plus count, modulo 2^32, as four bytes, most significant first. The count and the offset both reset to 0.
- R10: A successful power-off or reset command drives pwr_off or sys_rst high for exactly one cycle, in the same cycle as its reply.
- R11: A bus request raises bus_req for one cycle, one edge after the strobe. bus_req_len is the packet length minus 1, and bus_req_data holds packet bytes 1 and up. When bus_rsp_valid arrives with nonzero bus_rsp_len, the reply is 0x00, 0x00, then the data bytes, with length n+2, where n is bus_rsp_len limited to RSP_BYTES-2.
- R12: When bus_rsp_valid arrives with a bus_rsp_len of zero, the reply is 0x00, bus_rsp_err, then packet byte 1, with length 3.
- R13: While a bus response is pending, packet strobes are ignored: there is no reply and no new bus request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| sec_tick | input | 1 | One-cycle strobe once per second |
| pkt_valid | input | 1 | Packet handed over this cycle |
| pkt_len | input | PLW | Packet length in bytes |
| pkt_data | input | 8*PKT_BYTES | Packet bytes, byte i at bits 8i+7:8i |
| rsp_valid | output | 1 | Reply valid pulse |
| rsp_len | output | RLW | Reply length in bytes |
| rsp_data | output | 8*RSP_BYTES | Reply bytes, byte i at bits 8i+7:8i |
| bus_req | output | 1 | Bus request pulse |
| bus_req_len | output | PLW | Request payload length |
| bus_req_data | output | 8*(PKT_BYTES-1) | Request payload (packet bytes 1 and up) |
| bus_rsp_valid | input | 1 | Bus result available |
| bus_rsp_len | input | BLW | Result byte count; zero means failure |
| bus_rsp_err | input | 8 | Failure code magnitude |
| bus_rsp_data | input | 8*(RSP_BYTES-2) | Result bytes |
| autopoll_en | output | 1 | Autopoll enable |
| poll_rate | output | 8 | Poll rate |
| dev_mask | output | 16 | Device mask |
| pwr_off | output | 1 | Power-off pulse |
| sys_rst | output | 1 | System reset pulse |

## Verification
The bench builds the block with its default sizes: 8-byte packets and 8-byte replies. With those sizes, every command byte from 0x00 to 0xFF can be combined with every argument count from 0 to 6. The bench runs that full grid against an arithmetic model of the frames and the register state. Bus-result lengths from 0 to 7 are swept too, which reaches the clamp at 6. Directed cases cover clock wrap-around and a zero poll rate.

// File: rtl/pdsp_pkg.sv
package pdsp_pkg;
  localparam logic [7:0] TY_BUS = 8'h00;
  localparam logic [7:0] TY_CMD = 8'h01;
  localparam logic [7:0] TY_ERR = 8'h02;
  localparam logic [7:0] ERR_UNKNOWN = 8'h02;
  localparam logic [7:0] ERR_BADARG  = 8'h05;

  localparam logic [7:0] OP_AUTOPOLL = 8'h01;
  localparam logic [7:0] OP_CLK_RD   = 8'h03;
  localparam logic [7:0] OP_CLK_WR   = 8'h09;
  localparam logic [7:0] OP_PWR_OFF  = 8'h0A;
  localparam logic [7:0] OP_SYS_RST  = 8'h11;
  localparam logic [7:0] OP_FSRV     = 8'h13;
  localparam logic [7:0] OP_RATE     = 8'h14;
  localparam logic [7:0] OP_MASK     = 8'h19;
  localparam logic [7:0] OP_PMSG     = 8'h21;

  localparam int CLK_W = 32;

  typedef enum logic [2:0] {
    ACT_NONE, ACT_AUTOPOLL, ACT_CLK_WR, ACT_PWR_OFF, ACT_SYS_RST, ACT_RATE, ACT_MASK
  } act_e;

  typedef enum logic [1:0] {RES_OK, RES_BADARG, RES_UNKNOWN} res_e;

  typedef struct packed {
    res_e  res;
    act_e  act;
    logic  clk_rd;
  } verdict_t;

  typedef enum logic {ST_IDLE, ST_WAIT} st_e;
endpackage

// File: rtl/pdsp_cmd_check.sv
module pdsp_cmd_check
  import pdsp_pkg::*;
#(
  parameter int LW = 4
) (
  input  logic [7:0]    op,
  input  logic [LW-1:0] argc,
  input  logic [7:0]    arg0,
  output verdict_t      verdict
);
  logic          known;
  logic [LW-1:0] need;
  act_e          act;
  logic          rd;

  always_comb begin
    known = 1'b1;
    need  = '0;
    act   = ACT_NONE;
    rd    = 1'b0;
    case (op)
      OP_AUTOPOLL: begin need = LW'(1); act = ACT_AUTOPOLL; end
      OP_CLK_RD:   begin need = LW'(0); rd = 1'b1; end
      OP_CLK_WR:   begin need = LW'(4); act = ACT_CLK_WR; end
      OP_PWR_OFF:  begin need = LW'(0); act = ACT_PWR_OFF; end
      OP_SYS_RST:  begin need = LW'(0); act = ACT_SYS_RST; end
      OP_FSRV:     begin need = LW'(1); end
      OP_RATE:     begin need = LW'(1); act = ACT_RATE; end
      OP_MASK:     begin need = LW'(2); act = ACT_MASK; end
      OP_PMSG:     begin need = LW'(1); end
      default:     known = 1'b0;
    endcase

    verdict.act    = act;
    verdict.clk_rd = rd;
    if (!known)
      verdict.res = RES_UNKNOWN;
    else if ((argc != need) || ((act == ACT_RATE) && (arg0 == 8'h00)))
      verdict.res = RES_BADARG;
    else
      verdict.res = RES_OK;
  end
endmodule

// File: rtl/pdsp_rtc.sv
module pdsp_rtc
  import pdsp_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             set_en,
  input  logic [CLK_W-1:0] set_val,
  output logic [CLK_W-1:0] now
);
  logic [CLK_W-1:0] cnt_q, cnt_d, off_q, off_d;

  always_comb begin
    cnt_d = cnt_q;
    if (tick) cnt_d = cnt_q + 1'b1;
    off_d = off_q;
    if (set_en) off_d = set_val - cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      off_q <= '0;
    end else begin
      cnt_q <= cnt_d;
      off_q <= off_d;
    end
  end

  assign now = off_q + cnt_q;
endmodule

// File: rtl/cmd_pkt_dispatch.sv
module cmd_pkt_dispatch
  import pdsp_pkg::*;
#(
  parameter int          PKT_BYTES = 8,
  parameter int          RSP_BYTES = 8,
  parameter logic [7:0]  RATE_INIT = 8'd11,
  localparam int PLW     = $clog2(PKT_BYTES + 1),
  localparam int RLW     = $clog2(RSP_BYTES + 1),
  localparam int BUS_OUT = RSP_BYTES - 2,
  localparam int BLW     = $clog2(BUS_OUT + 2)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       sec_tick,
  input  logic                       pkt_valid,
  input  logic [PLW-1:0]             pkt_len,
  input  logic [8*PKT_BYTES-1:0]     pkt_data,
  output logic                       rsp_valid,
  output logic [RLW-1:0]             rsp_len,
  output logic [8*RSP_BYTES-1:0]     rsp_data,
  output logic                       bus_req,
  output logic [PLW-1:0]             bus_req_len,
  output logic [8*(PKT_BYTES-1)-1:0] bus_req_data,
  input  logic                       bus_rsp_valid,
  input  logic [BLW-1:0]             bus_rsp_len,
  input  logic [7:0]                 bus_rsp_err,
  input  logic [8*BUS_OUT-1:0]       bus_rsp_data,
  output logic                       autopoll_en,
  output logic [7:0]                 poll_rate,
  output logic [15:0]                dev_mask,
  output logic                       pwr_off,
  output logic                       sys_rst
);
  // reset: asserted asynchronously, released through two flops
  logic rs0_q, srst_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs0_q  <= 1'b0;
      srst_n <= 1'b0;
    end else begin
      rs0_q  <= 1'b1;
      srst_n <= rs0_q;
    end
  end

  logic [7:0] b [PKT_BYTES];
  for (genvar gi = 0; gi < PKT_BYTES; gi++) begin : g_unpack
    assign b[gi] = pkt_data[8*gi +: 8];
  end

  st_e      state_q, state_d;
  logic     accept_cmd, accept_bus, ok;
  logic [PLW-1:0] argc;
  verdict_t vd;
  logic [CLK_W-1:0] now;

  assign accept_cmd = pkt_valid && (state_q == ST_IDLE) && (pkt_len >= PLW'(2)) && (b[0] == TY_CMD);
  assign accept_bus = pkt_valid && (state_q == ST_IDLE) && (pkt_len >= PLW'(1)) && (b[0] == TY_BUS);
  assign argc       = pkt_len - PLW'(2);
  assign ok         = accept_cmd && (vd.res == RES_OK);

  pdsp_cmd_check #(.LW(PLW)) u_check (
    .op(b[1]), .argc(argc), .arg0(b[2]), .verdict(vd)
  );

  pdsp_rtc u_rtc (
    .clk(clk), .rst_n(srst_n), .tick(sec_tick),
    .set_en(ok && (vd.act == ACT_CLK_WR)),
    .set_val({b[2], b[3], b[4], b[5]}),
    .now(now)
  );

  // reply assembly
  logic                   rsp_v_d;
  logic [RLW-1:0]         rsp_len_d;
  logic [8*RSP_BYTES-1:0] rsp_d;
  logic [BLW-1:0]         n_eff;
  logic [7:0]             echo_q;

  assign n_eff = (bus_rsp_len > BLW'(BUS_OUT)) ? BLW'(BUS_OUT) : bus_rsp_len;

  always_comb begin
    rsp_v_d   = 1'b0;
    rsp_len_d = '0;
    rsp_d     = '0;
    if (accept_cmd) begin
      rsp_v_d = 1'b1;
      if (vd.res == RES_OK) begin
        rsp_d[7:0]   = TY_CMD;
        rsp_d[23:16] = b[1];
        rsp_len_d    = RLW'(3);
        if (vd.clk_rd) begin
          rsp_d[31:24] = now[31:24];
          rsp_d[39:32] = now[23:16];
          rsp_d[47:40] = now[15:8];
          rsp_d[55:48] = now[7:0];
          rsp_len_d    = RLW'(7);
        end
      end else begin
        rsp_d[7:0]   = TY_ERR;
        rsp_d[15:8]  = (vd.res == RES_BADARG) ? ERR_BADARG : ERR_UNKNOWN;
        rsp_d[23:16] = TY_CMD;
        rsp_d[31:24] = b[1];
        rsp_len_d    = RLW'(4);
      end
    end else if ((state_q == ST_WAIT) && bus_rsp_valid) begin
      rsp_v_d    = 1'b1;
      rsp_d[7:0] = TY_BUS;
      if (bus_rsp_len != '0) begin
        for (int i = 0; i < BUS_OUT; i++)
          if (i < int'(n_eff)) rsp_d[8*(i+2) +: 8] = bus_rsp_data[8*i +: 8];
        rsp_len_d = RLW'(n_eff) + RLW'(2);
      end else begin
        rsp_d[15:8]  = bus_rsp_err;
        rsp_d[23:16] = echo_q;
        rsp_len_d    = RLW'(3);
      end
    end
  end

  always_comb begin
    state_d = state_q;
    if ((state_q == ST_IDLE) && accept_bus) state_d = ST_WAIT;
    else if ((state_q == ST_WAIT) && bus_rsp_valid) state_d = ST_IDLE;
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      state_q      <= ST_IDLE;
      rsp_valid    <= 1'b0;
      rsp_len      <= '0;
      rsp_data     <= '0;
      bus_req      <= 1'b0;
      bus_req_len  <= '0;
      bus_req_data <= '0;
      echo_q       <= '0;
      autopoll_en  <= 1'b0;
      poll_rate    <= RATE_INIT;
      dev_mask     <= '0;
      pwr_off      <= 1'b0;
      sys_rst      <= 1'b0;
    end else begin
      state_q   <= state_d;
      rsp_valid <= rsp_v_d;
      bus_req   <= accept_bus;
      pwr_off   <= ok && (vd.act == ACT_PWR_OFF);
      sys_rst   <= ok && (vd.act == ACT_SYS_RST);
      if (rsp_v_d) begin
        rsp_len  <= rsp_len_d;
        rsp_data <= rsp_d;
      end
      if (accept_bus) begin
        bus_req_len  <= pkt_len - PLW'(1);
        bus_req_data <= pkt_data[8*PKT_BYTES-1:8];
        echo_q       <= b[1];
      end
      if (ok && (vd.act == ACT_AUTOPOLL)) autopoll_en <= (b[2] != 8'h00);
      if (ok && (vd.act == ACT_RATE))     poll_rate   <= b[2];
      if (ok && (vd.act == ACT_MASK))     dev_mask    <= {b[2], b[3]};
    end
  end
endmodule

// File: rtl/pdsp_chk.sv
module pdsp_chk #(
  parameter int RSP_BYTES = 8,
  parameter int RLW = 4
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   rsp_valid,
  input logic [RLW-1:0]         rsp_len,
  input logic [8*RSP_BYTES-1:0] rsp_data,
  input logic                   bus_req,
  input logic [15:0]            dev_mask,
  input logic                   pwr_off,
  input logic                   sys_rst
);
  // R2
  cmd_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_data[7:0] == 8'h01) |->
      (rsp_data[15:8] == 8'h00 && (rsp_len == RLW'(3) || rsp_len == RLW'(7))));

  // R3 R4
  err_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_data[7:0] == 8'h02) |->
      (rsp_len == RLW'(4) && rsp_data[23:16] == 8'h01 &&
       (rsp_data[15:8] == 8'h02 || rsp_data[15:8] == 8'h05)));

  // R10
  pwr_off_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_off |-> (rsp_valid && rsp_data[7:0] == 8'h01 && rsp_data[23:16] == 8'h0A));

  // R10
  sys_rst_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sys_rst |-> (rsp_valid && rsp_data[7:0] == 8'h01 && rsp_data[23:16] == 8'h11));

  // R8
  mask_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(dev_mask) |-> (rsp_valid && rsp_data[23:16] == 8'h19));

  // R11
  bus_req_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req |=> !bus_req);

  // R13
  bus_req_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req |-> !rsp_valid);
endmodule

bind cmd_pkt_dispatch pdsp_chk #(.RSP_BYTES(RSP_BYTES), .RLW(RLW)) u_chk (
  .clk(clk), .rst_n(srst_n), .rsp_valid(rsp_valid), .rsp_len(rsp_len),
  .rsp_data(rsp_data), .bus_req(bus_req), .dev_mask(dev_mask),
  .pwr_off(pwr_off), .sys_rst(sys_rst)
);

// File: tb/sim_cmd_pkt_dispatch.sv
`timescale 1ns/1ps
module sim_cmd_pkt_dispatch;
  localparam int PKT_BYTES = 8;
  localparam int RSP_BYTES = 8;
  localparam int PLW = 4;
  localparam int RLW = 4;
  localparam int BLW = 3;
  localparam logic [7:0] RATE_INIT = 8'd11;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, sec_tick, pkt_valid, bus_rsp_valid;
  logic [PLW-1:0] pkt_len;
  logic [63:0] pkt_data;
  logic rsp_valid, bus_req, autopoll_en, pwr_off, sys_rst;
  logic [RLW-1:0] rsp_len;
  logic [63:0] rsp_data;
  logic [PLW-1:0] bus_req_len;
  logic [55:0] bus_req_data;
  logic [BLW-1:0] bus_rsp_len;
  logic [7:0] bus_rsp_err, poll_rate;
  logic [47:0] bus_rsp_data;
  logic [15:0] dev_mask;

  cmd_pkt_dispatch #(.PKT_BYTES(PKT_BYTES), .RSP_BYTES(RSP_BYTES), .RATE_INIT(RATE_INIT)) u0 (
    .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .pkt_valid(pkt_valid),
    .pkt_len(pkt_len), .pkt_data(pkt_data), .rsp_valid(rsp_valid), .rsp_len(rsp_len),
    .rsp_data(rsp_data), .bus_req(bus_req), .bus_req_len(bus_req_len),
    .bus_req_data(bus_req_data), .bus_rsp_valid(bus_rsp_valid), .bus_rsp_len(bus_rsp_len),
    .bus_rsp_err(bus_rsp_err), .bus_rsp_data(bus_rsp_data), .autopoll_en(autopoll_en),
    .poll_rate(poll_rate), .dev_mask(dev_mask), .pwr_off(pwr_off), .sys_rst(sys_rst)
  );

  int checks = 0;
  int fails = 0;
  logic m_auto;
  logic [7:0] m_rate;
  logic [15:0] m_mask;
  logic [31:0] m_off, m_cnt;

  task automatic chk(input bit good, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!good) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk); sec_tick = 1'b1;
    @(negedge clk); sec_tick = 1'b0;
    m_cnt = m_cnt + 1;
  endtask

  task automatic check_regs(input string tag);
    chk(autopoll_en == m_auto, {tag, " R7 autopoll"}, 64'(autopoll_en), 64'(m_auto));
    chk(poll_rate == m_rate, {tag, " R6 rate"}, 64'(poll_rate), 64'(m_rate));
    chk(dev_mask == m_mask, {tag, " R8 mask"}, 64'(dev_mask), 64'(m_mask));
  endtask

  // Send a command packet and check reply, pulses and registers
  task automatic send_cmd(input logic [7:0] op, input int argc, input logic [47:0] args);
    logic [63:0] pd, exp;
    int need, elen;
    logic good_args, ok;
    logic [31:0] v;
    pd = '0;
    pd[7:0] = 8'h01;
    pd[15:8] = op;
    for (int i = 0; i < argc; i++) pd[8*(i+2) +: 8] = args[8*i +: 8];
    case (op)
      8'h01, 8'h13, 8'h14, 8'h21: need = 1;
      8'h03, 8'h0A, 8'h11: need = 0;
      8'h09: need = 4;
      8'h19: need = 2;
      default: need = -1;
    endcase
    good_args = (argc == need) && !(op == 8'h14 && pd[23:16] == 8'h00);
    ok = (need >= 0) && good_args;
    exp = '0;
    if (need < 0) begin
      exp = {32'h0, op, 8'h01, 8'h02, 8'h02}; elen = 4;
    end else if (!good_args) begin
      exp = {32'h0, op, 8'h01, 8'h05, 8'h02}; elen = 4;
    end else begin
      exp = {40'h0, op, 8'h00, 8'h01}; elen = 3;
      if (op == 8'h03) begin
        v = m_off + m_cnt;
        exp[55:24] = {v[7:0], v[15:8], v[23:16], v[31:24]};
        elen = 7;
      end
    end
    @(negedge clk);
    pkt_data = pd; pkt_len = PLW'(argc + 2); pkt_valid = 1'b1;
    @(negedge clk);
    pkt_valid = 1'b0;
    if (ok) begin
      case (op)
        8'h01: m_auto = (pd[23:16] != 8'h00);
        8'h14: m_rate = pd[23:16];
        8'h19: m_mask = {pd[23:16], pd[31:24]};
        8'h09: m_off = {pd[23:16], pd[31:24], pd[39:32], pd[47:40]} - m_cnt;
        default: ;
      endcase
    end
    chk(rsp_valid == 1'b1, "R2 reply pulse", 64'(rsp_valid), 64'd1);
    chk(rsp_len == RLW'(elen), (need < 0) ? "R4 len" : (ok ? "R2 len" : "R3 len"), 64'(rsp_len), 64'(elen));
    chk(rsp_data == exp, (need < 0) ? "R4 frame" : (ok ? "R5 frame" : "R3 frame"), rsp_data, exp);
    chk(pwr_off == (ok && op == 8'h0A), "R10 pwr_off", 64'(pwr_off), 64'(ok && op == 8'h0A));
    chk(sys_rst == (ok && op == 8'h11), "R10 sys_rst", 64'(sys_rst), 64'(ok && op == 8'h11));
    check_regs("cmd");
  endtask

  task automatic send_ignored(input logic [7:0] ty, input int len, input string tag);
    @(negedge clk);
    pkt_data = {48'h0, 8'h01, ty}; pkt_len = PLW'(len); pkt_valid = 1'b1;
    @(negedge clk);
    pkt_valid = 1'b0;
    chk(rsp_valid == 1'b0, tag, 64'(rsp_valid), 64'd0);
    chk(bus_req == 1'b0, tag, 64'(bus_req), 64'd0);
  endtask

  task automatic bus_txn(input int len, input logic [63:0] pd_in, input int rlen,
                         input logic [7:0] err, input logic [47:0] rdata);
    logic [63:0] pd, exp;
    int n, elen;
    pd = pd_in; pd[7:0] = 8'h00;
    @(negedge clk);
    pkt_data = pd; pkt_len = PLW'(len); pkt_valid = 1'b1;
    @(negedge clk);
    pkt_valid = 1'b0;
    chk(bus_req == 1'b1, "R11 bus_req", 64'(bus_req), 64'd1);
    chk(bus_req_len == PLW'(len - 1), "R11 req len", 64'(bus_req_len), 64'(len - 1));
    chk(bus_req_data == pd[63:8], "R11 req data", 64'(bus_req_data), 64'(pd[63:8]));
    chk(rsp_valid == 1'b0, "R13 no early reply", 64'(rsp_valid), 64'd0);
    // a command sent while waiting must be dropped
    pkt_data = {48'h0, 8'h03, 8'h01}; pkt_len = PLW'(2); pkt_valid = 1'b1;
    @(negedge clk);
    pkt_valid = 1'b0;
    chk(rsp_valid == 1'b0, "R13 busy drop", 64'(rsp_valid), 64'd0);
    chk(bus_req == 1'b0, "R13 busy no req", 64'(bus_req), 64'd0);
    @(negedge clk);
    bus_rsp_valid = 1'b1; bus_rsp_len = BLW'(rlen); bus_rsp_err = err; bus_rsp_data = rdata;
    @(negedge clk);
    bus_rsp_valid = 1'b0;
    exp = '0;
    if (rlen != 0) begin
      n = (rlen > 6) ? 6 : rlen;
      for (int i = 0; i < n; i++) exp[8*(i+2) +: 8] = rdata[8*i +: 8];
      elen = n + 2;
    end else begin
      exp[15:8] = err; exp[23:16] = pd[15:8]; elen = 3;
    end
    chk(rsp_valid == 1'b1, "R11 bus reply pulse", 64'(rsp_valid), 64'd1);
    chk(rsp_len == RLW'(elen), (rlen != 0) ? "R11 len" : "R12 len", 64'(rsp_len), 64'(elen));
    chk(rsp_data == exp, (rlen != 0) ? "R11 frame" : "R12 frame", rsp_data, exp);
  endtask

  bit done = 1'b0;

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog all-requirements actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; sec_tick = 1'b0; pkt_valid = 1'b0; pkt_len = '0; pkt_data = '0;
    bus_rsp_valid = 1'b0; bus_rsp_len = '0; bus_rsp_err = '0; bus_rsp_data = '0;
    m_auto = 1'b0; m_rate = RATE_INIT; m_mask = '0; m_off = '0; m_cnt = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // reset state
    chk(rsp_valid == 1'b0, "R2 reset rsp_valid", 64'(rsp_valid), 64'd0);
    chk(bus_req == 1'b0, "R11 reset bus_req", 64'(bus_req), 64'd0);
    chk(pwr_off == 1'b0 && sys_rst == 1'b0, "R10 reset pulses", 64'({pwr_off, sys_rst}), 64'd0);
    check_regs("reset");
    send_cmd(8'h03, 0, 48'h0);  // R9 clock reads zero after reset

    // R1 dropped packets
    for (int t = 2; t < 10; t++) send_ignored(8'(t), 3, "R1 other type");
    send_ignored(8'h01, 1, "R1 short command");
    send_ignored(8'h00, 0, "R1 empty packet");

    // full command grid
    for (int op = 0; op < 256; op++) begin
      for (int argc = 0; argc <= 6; argc++) begin
        logic [47:0] a;
        for (int i = 0; i < 6; i++) a[8*i +: 8] = 8'(op * 7 + i * 53 + argc * 11);
        send_cmd(8'(op), argc, a);
      end
      if (op % 16 == 5) tick();
    end

    // R6 zero rate rejected, nonzero accepted
    send_cmd(8'h14, 1, 48'h000000000000);
    send_cmd(8'h14, 1, 48'h0000000000C8);
    // R7 autopoll off then on
    send_cmd(8'h01, 1, 48'h0);
    send_cmd(8'h01, 1, 48'h80);
    // R8 byte order of mask
    send_cmd(8'h19, 2, 48'h00000000CDAB);
    // R9 set, tick, read; wrap-around
    send_cmd(8'h09, 4, 48'h000078563412);
    tick(); tick(); tick();
    send_cmd(8'h03, 0, 48'h0);
    send_cmd(8'h09, 4, 48'h0000FFFFFFFF);
    tick();
    send_cmd(8'h03, 0, 48'h0);
    // R10 pulse lasts one cycle
    send_cmd(8'h0A, 0, 48'h0);
    @(negedge clk);
    chk(pwr_off == 1'b0, "R10 pwr_off width", 64'(pwr_off), 64'd0);
    send_cmd(8'h11, 0, 48'h0);
    @(negedge clk);
    chk(sys_rst == 1'b0, "R10 sys_rst width", 64'(sys_rst), 64'd0);

    // bus requests: result lengths 0..7
    for (int r = 0; r < 8; r++)
      bus_txn(2 + (r % 6), {8'h77, 8'h66, 8'h55, 8'h44, 8'h33, 8'h22, 8'(8'h10 + r), 8'h00},
              r, 8'(8'hF0 + r), 48'hA5A4A3A2A1A0 ^ 48'(r));
    bus_txn(1, 64'h0, 0, 8'h03, 48'h0);
    // dispatcher idle again: command answered
    send_cmd(8'h13, 1, 48'h5);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule